// File: doc/BRIEF.md
# Page Aging Tracker

This block keeps the replacement state for a fixed pool of physical frames. Each frame sits in one of two groups, active or inactive, and carries an accessed flag and a dirty flag. The memory system reports every read or write that touches a frame. A periodic aging tick pushes one active frame at a time into the inactive group and clears its accessed flag. A frame that is touched again, whichever group it is in, returns to the active group at once.

When a free frame is needed, an eviction request starts a search with a second circular hand. The hand looks at one frame per cycle and stops at the first frame that is inactive and has not been accessed. If that victim is dirty, the block holds it on its outputs until the write-back has been acknowledged. If no frame qualifies within one full sweep, the block reports that instead. The victim frame is then treated as holding a freshly installed page: it becomes active and accessed, and its dirty flag is clear. The swap transfer and the page table update stay outside the block.

Top module: `page_age_tracker`

## Requirements
- R1: After reset every frame is inactive, with its accessed and dirty flags clear, and victimValid and noVictim are low.
- R2: A touch (touchValid high) of a frame, read or write, makes that frame active with its accessed flag set from the next cycle on, whichever group it was in before.
- R3: A touch with touchWrite high also sets the frame's dirty flag. A touch with touchWrite low leaves the dirty flag unchanged.
- R4: An aging tick finds the first active frame at or after the aging hand, in circular order of increasing index. It moves that frame to the inactive group, clears its accessed flag and places the hand on the next index. At most one frame is demoted per tick, and a tick with no active frame changes nothing.
- R5: When a touch and an aging tick pick the same frame in the same cycle, the frame stays active with its accessed flag set, and the aging hand still advances past it.
- R6: An eviction request seen while idle starts a scan at the victim hand, one frame per cycle. The victim is the first frame that is inactive with its accessed flag clear. If k frames are skipped first, victimValid rises k+1 cycles after the request edge, victimFrame gives the index, and the hand moves to the next index after the victim.
- R7: If no frame qualifies within NUM_FRAMES frames, noVictim is high for exactly one cycle, NUM_FRAMES cycles after the request edge. victimValid stays low and the victim hand ends where it started.
- R8: While victimValid is high, victimDirty shows the victim's dirty flag. A clean victim holds victimValid for exactly one cycle.
- R9: A dirty victim holds victimValid until the cycle in which wbAck is high. victimValid drops in the next cycle.
- R10: When an eviction completes, the victim frame becomes active with its accessed flag set and its dirty flag clear.
- R11: An eviction request that arrives while a scan or a held victim is in progress is ignored and starts no later scan.
- R12: victimValid and noVictim are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| touchValid | input | 1 | A frame was accessed this cycle |
| touchFrame | input | $clog2(NUM_FRAMES) | Index of the accessed frame |
| touchWrite | input | 1 | The access was a write |
| ageTick | input | 1 | Demote one active frame |
| evictReq | input | 1 | Start a victim search |
| wbAck | input | 1 | Write-back of the held dirty victim is done |
| victimValid | output | 1 | victimFrame holds the chosen victim |
| victimFrame | output | $clog2(NUM_FRAMES) | Index of the victim |
| victimDirty | output | 1 | The victim needs write-back |
| noVictim | output | 1 | One-cycle pulse: the full sweep found no candidate |
| activeMask | output | NUM_FRAMES | Bit i set: frame i is in the active group |
| accessedMask | output | NUM_FRAMES | Accessed flag of each frame |
| dirtyMask | output | NUM_FRAMES | Dirty flag of each frame |

## Verification
Touches and aging ticks reach the three masks one cycle after the edge that samples them, and the bench compares all three against its own model at that point. An eviction result is due k+1 cycles after the request edge, where k is the number of frames the model skips from its own hand. A sweep with no candidate is due after NUM_FRAMES cycles. The bench counts cycles to exactly that point: it requires both result outputs to be low before it and checks the victim on it. Install state is checked one cycle after the completing edge. For dirty victims, that edge is the one that samples wbAck.

// File: rtl/page_age_pkg.sv
package page_age_pkg;

  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_SCAN = 2'd1,
    EV_HOLD = 2'd2,
    EV_NONE = 2'd3
  } evictState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic scanStep;     // advance victim hand by one frame
    logic latchVictim;  // capture the victim hand as the victim
    logic install;      // eviction finished: reinstall victim frame
  } ctlStrobe_t;

endpackage

// File: rtl/page_age_ctrl.sv
module page_age_ctrl
  import page_age_pkg::*;
#(
  parameter int NUM_FRAMES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evictReq,
  input  logic       wbAck,
  input  logic       vicHit,
  input  logic       victimDirtyNow,
  output ctlStrobe_t strobes,
  output logic       victimValid,
  output logic       noVictim
);

  localparam int IDXW = $clog2(NUM_FRAMES);
  localparam logic [IDXW-1:0] LAST_STEP = IDXW'(NUM_FRAMES - 1);

  evictState_e state, stateNext;
  logic [IDXW-1:0] scanCnt, scanCntNext;

  always_comb begin
    stateNext   = state;
    scanCntNext = scanCnt;
    strobes     = '0;
    case (state)
      EV_IDLE: begin
        if (evictReq) begin
          stateNext   = EV_SCAN;
          scanCntNext = '0;
        end
      end
      EV_SCAN: begin
        strobes.scanStep = 1'b1;
        if (vicHit) begin
          strobes.latchVictim = 1'b1;
          stateNext           = EV_HOLD;
        end else if (scanCnt == LAST_STEP) begin
          stateNext = EV_NONE;
        end else begin
          scanCntNext = scanCnt + 1'b1;
        end
      end
      EV_HOLD: begin
        if (!victimDirtyNow || wbAck) begin
          strobes.install = 1'b1;
          stateNext       = EV_IDLE;
        end
      end
      default: stateNext = EV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= EV_IDLE;
      scanCnt <= '0;
    end else begin
      state   <= stateNext;
      scanCnt <= scanCntNext;
    end
  end

  assign victimValid = (state == EV_HOLD);
  assign noVictim    = (state == EV_NONE);

endmodule

// File: rtl/page_age_dpath.sv
module page_age_dpath
  import page_age_pkg::*;
#(
  parameter int NUM_FRAMES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          touchValid,
  input  logic [$clog2(NUM_FRAMES)-1:0] touchFrame,
  input  logic                          touchWrite,
  input  logic                          ageTick,
  input  ctlStrobe_t                    strobes,
  output logic                          vicHit,
  output logic                          victimDirtyNow,
  output logic [$clog2(NUM_FRAMES)-1:0] victimFrame,
  output logic [NUM_FRAMES-1:0]         activeMask,
  output logic [NUM_FRAMES-1:0]         accessedMask,
  output logic [NUM_FRAMES-1:0]         dirtyMask
);

  localparam int IDXW = $clog2(NUM_FRAMES);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_FRAMES - 1);

  function automatic logic [IDXW-1:0] nextIdx(input logic [IDXW-1:0] cur);
    return (cur == LAST_IDX) ? '0 : cur + 1'b1;
  endfunction

  logic [NUM_FRAMES-1:0] actR, accR, drtR;
  logic [NUM_FRAMES-1:0] actN, accN, drtN;
  logic [IDXW-1:0]       ageHand, vicHand, victimR;
  logic [IDXW-1:0]       agePick;
  logic                  ageFound;

  // First active frame at or after the aging hand (circular).
  always_comb begin
    logic [IDXW-1:0] idx;
    ageFound = 1'b0;
    agePick  = '0;
    for (int k = NUM_FRAMES - 1; k >= 0; k--) begin
      idx = IDXW'((32'(ageHand) + 32'(k)) % NUM_FRAMES);
      if (actR[idx]) begin
        ageFound = 1'b1;
        agePick  = idx;
      end
    end
  end

  // Flag update order: demotion, then install, then touch (touch wins).
  always_comb begin
    actN = actR;
    accN = accR;
    drtN = drtR;
    if (ageTick && ageFound) begin
      actN[agePick] = 1'b0;
      accN[agePick] = 1'b0;
    end
    if (strobes.install) begin
      actN[victimR] = 1'b1;
      accN[victimR] = 1'b1;
      drtN[victimR] = 1'b0;
    end
    if (touchValid) begin
      actN[touchFrame] = 1'b1;
      accN[touchFrame] = 1'b1;
      if (touchWrite) drtN[touchFrame] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actR    <= '0;
      accR    <= '0;
      drtR    <= '0;
      ageHand <= '0;
      vicHand <= '0;
      victimR <= '0;
    end else begin
      actR <= actN;
      accR <= accN;
      drtR <= drtN;
      if (ageTick && ageFound) ageHand <= nextIdx(agePick);
      if (strobes.scanStep)    vicHand <= nextIdx(vicHand);
      if (strobes.latchVictim) victimR <= vicHand;
    end
  end

  assign vicHit         = !actR[vicHand] && !accR[vicHand];
  assign victimDirtyNow = drtR[victimR];
  assign victimFrame    = victimR;
  assign activeMask     = actR;
  assign accessedMask   = accR;
  assign dirtyMask      = drtR;

endmodule

// File: rtl/page_age_tracker.sv
module page_age_tracker
  import page_age_pkg::*;
#(
  parameter int NUM_FRAMES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          touchValid,
  input  logic [$clog2(NUM_FRAMES)-1:0] touchFrame,
  input  logic                          touchWrite,
  input  logic                          ageTick,
  input  logic                          evictReq,
  input  logic                          wbAck,
  output logic                          victimValid,
  output logic [$clog2(NUM_FRAMES)-1:0] victimFrame,
  output logic                          victimDirty,
  output logic                          noVictim,
  output logic [NUM_FRAMES-1:0]         activeMask,
  output logic [NUM_FRAMES-1:0]         accessedMask,
  output logic [NUM_FRAMES-1:0]         dirtyMask
);

  ctlStrobe_t strobes;
  logic       vicHit;
  logic       victimDirtyNow;

  page_age_ctrl #(.NUM_FRAMES(NUM_FRAMES)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .evictReq      (evictReq),
    .wbAck         (wbAck),
    .vicHit        (vicHit),
    .victimDirtyNow(victimDirtyNow),
    .strobes       (strobes),
    .victimValid   (victimValid),
    .noVictim      (noVictim)
  );

  page_age_dpath #(.NUM_FRAMES(NUM_FRAMES)) dpath_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .touchValid    (touchValid),
    .touchFrame    (touchFrame),
    .touchWrite    (touchWrite),
    .ageTick       (ageTick),
    .strobes       (strobes),
    .vicHit        (vicHit),
    .victimDirtyNow(victimDirtyNow),
    .victimFrame   (victimFrame),
    .activeMask    (activeMask),
    .accessedMask  (accessedMask),
    .dirtyMask     (dirtyMask)
  );

  assign victimDirty = victimValid && victimDirtyNow;

endmodule

// File: rtl/page_age_checker.sv
module page_age_checker #(
  parameter int NUM_FRAMES = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          touchValid,
  input logic [$clog2(NUM_FRAMES)-1:0] touchFrame,
  input logic                          touchWrite,
  input logic                          wbAck,
  input logic                          victimValid,
  input logic [$clog2(NUM_FRAMES)-1:0] victimFrame,
  input logic                          victimDirty,
  input logic                          noVictim,
  input logic [NUM_FRAMES-1:0]         activeMask,
  input logic [NUM_FRAMES-1:0]         accessedMask,
  input logic [NUM_FRAMES-1:0]         dirtyMask
);

  logic [NUM_FRAMES-1:0] vicOneHot;
  assign vicOneHot = {{(NUM_FRAMES-1){1'b0}}, 1'b1} << victimFrame;

  // R12: results are mutually exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({victimValid, noVictim}));

  // R4: at most one frame leaves the active group per cycle
  a_r4_single_demotion: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones($past(activeMask) & ~activeMask) <= 1));

  // R4: a demoted frame has its accessed flag cleared
  a_r4_demote_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(activeMask) & ~activeMask & accessedMask) == '0));

  // R2: a touched frame is active next cycle
  a_r2_touch_active: assert property (@(posedge clk) disable iff (!rst_n)
    touchValid |=> ((activeMask & accessedMask & ({{(NUM_FRAMES-1){1'b0}}, 1'b1} << $past(touchFrame))) != '0));

  // R3: a write touch makes the frame dirty
  a_r3_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (touchValid && touchWrite) |=> ((dirtyMask & ({{(NUM_FRAMES-1){1'b0}}, 1'b1} << $past(touchFrame))) != '0));

  // R9: a dirty victim stays until write-back is acknowledged
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (victimValid && victimDirty && !wbAck) |=> victimValid);

  // R6: a new victim was inactive and unaccessed when chosen
  a_r6_victim_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(victimValid) |-> ((($past(activeMask) | $past(accessedMask)) & vicOneHot) == '0));

endmodule

bind page_age_tracker page_age_checker #(.NUM_FRAMES(NUM_FRAMES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .touchValid  (touchValid),
  .touchFrame  (touchFrame),
  .touchWrite  (touchWrite),
  .wbAck       (wbAck),
  .victimValid (victimValid),
  .victimFrame (victimFrame),
  .victimDirty (victimDirty),
  .noVictim    (noVictim),
  .activeMask  (activeMask),
  .accessedMask(accessedMask),
  .dirtyMask   (dirtyMask)
);

// File: tb/page_age_tracker_tb_top.sv
module page_age_tracker_tb_top;

  localparam int NF = 16;
  localparam int IW = $clog2(NF);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          touchValid = 1'b0, touchWrite = 1'b0, ageTick = 1'b0;
  logic          evictReq = 1'b0, wbAck = 1'b0;
  logic [IW-1:0] touchFrame = '0;
  logic          victimValid, victimDirty, noVictim;
  logic [IW-1:0] victimFrame;
  logic [NF-1:0] activeMask, accessedMask, dirtyMask;

  page_age_tracker #(.NUM_FRAMES(NF)) dut_i (
    .clk(clk), .rst_n(rst_n), .touchValid(touchValid), .touchFrame(touchFrame),
    .touchWrite(touchWrite), .ageTick(ageTick), .evictReq(evictReq), .wbAck(wbAck),
    .victimValid(victimValid), .victimFrame(victimFrame), .victimDirty(victimDirty),
    .noVictim(noVictim), .activeMask(activeMask), .accessedMask(accessedMask),
    .dirtyMask(dirtyMask)
  );

  int checks = 0, errors = 0;
  logic [NF-1:0] mAct = '0, mAcc = '0, mDrt = '0;
  int mAgeHand = 0, mVicHand = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmpMasks(string req);
    check(activeMask == mAct, req, "activeMask", int'(activeMask), int'(mAct));
    check(accessedMask == mAcc, req, "accessedMask", int'(accessedMask), int'(mAcc));
    check(dirtyMask == mDrt, req, "dirtyMask", int'(dirtyMask), int'(mDrt));
  endtask

  function automatic int modelAgePick();
    for (int k = 0; k < NF; k++) begin
      if (mAct[(mAgeHand + k) % NF]) return (mAgeHand + k) % NF;
    end
    return -1;
  endfunction

  task automatic doOp(bit t, int f, bit w, bit a, string req);
    int p;
    touchValid = t; touchFrame = IW'(f); touchWrite = w; ageTick = a;
    step();
    touchValid = 0; touchWrite = 0; ageTick = 0;
    if (a) begin
      p = modelAgePick();
      if (p >= 0) begin
        mAct[p] = 0; mAcc[p] = 0; mAgeHand = (p + 1) % NF;
      end
    end
    if (t) begin
      mAct[f] = 1; mAcc[f] = 1;
      if (w) mDrt[f] = 1;
    end
    cmpMasks(req);
  endtask

  task automatic doEvict(bit poke);
    int k = 0, idx = 0, lat;
    bit found = 0, early = 0, quiet = 1, wasDirty;
    for (int j = 0; j < NF; j++) begin
      int p = (mVicHand + j) % NF;
      if (!found && !mAct[p] && !mAcc[p]) begin
        found = 1; idx = p; k = j;
      end
    end
    lat = found ? k + 1 : NF;
    evictReq = 1;
    step();
    evictReq = 0;
    for (int j = 1; j <= lat; j++) begin
      if (poke && j == 1) evictReq = 1;   // R11: ignored while scanning
      step();
      evictReq = 0;
      if (j < lat && (victimValid || noVictim)) early = 1;
    end
    check(!early, "R6", "result before due cycle", int'(early), 0);
    if (found) begin
      wasDirty = mDrt[idx];
      check(victimValid == 1, "R6", "victimValid", int'(victimValid), 1);
      check(victimFrame == IW'(idx), "R6", "victimFrame", int'(victimFrame), idx);
      check(noVictim == 0, "R12", "noVictim with victim", int'(noVictim), 0);
      check(victimDirty == wasDirty, "R8", "victimDirty", int'(victimDirty), int'(wasDirty));
      if (wasDirty) begin
        for (int j = 0; j < 3; j++) begin
          if (poke && j == 1) evictReq = 1;   // R11: ignored while held
          step();
          evictReq = 0;
          check(victimValid == 1, "R9", "victim held before ack", int'(victimValid), 1);
        end
        wbAck = 1;
        step();
        wbAck = 0;
        check(victimValid == 0, "R9", "victimValid after ack", int'(victimValid), 0);
      end else begin
        step();
        check(victimValid == 0, "R8", "clean victim one cycle", int'(victimValid), 0);
      end
      mAct[idx] = 1; mAcc[idx] = 1; mDrt[idx] = 0;
      mVicHand = (idx + 1) % NF;
      cmpMasks("R10");
    end else begin
      check(noVictim == 1 && victimValid == 0, "R7", "noVictim due", int'({noVictim, victimValid}), 2);
      step();
      check(noVictim == 0, "R7", "noVictim one cycle", int'(noVictim), 0);
      cmpMasks("R7");
    end
    if (poke) begin
      for (int j = 0; j < NF + 2; j++) begin
        step();
        if (victimValid || noVictim) quiet = 0;
      end
      check(quiet, "R11", "extra request started a scan", int'(!quiet), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1: reset state
    cmpMasks("R1");
    check(victimValid == 0 && noVictim == 0, "R1", "result outputs", int'({victimValid, noVictim}), 0);

    // R2: read touches promote every frame
    for (int f = 0; f < NF; f++) doOp(1, f, 0, 0, "R2");
    // R3: writes set dirty, a later read keeps it
    doOp(1, 3, 1, 0, "R3");
    doOp(1, 7, 1, 0, "R3");
    doOp(1, 3, 0, 0, "R3");

    // R7: everything active, no victim; R11 poke during scan
    doEvict(1);

    // R4: demote a few frames in hand order
    for (int i = 0; i < 5; i++) doOp(0, 0, 0, 1, "R4");
    // R5: touch and age on the same frame
    p = modelAgePick();
    doOp(1, p, 0, 1, "R5");
    doOp(0, 0, 0, 1, "R4");

    // R6/R8/R10: clean and dirty victims
    doEvict(0);
    doEvict(0);
    for (int i = 0; i < 4; i++) doOp(0, 0, 0, 1, "R4");
    doEvict(1);
    doEvict(0);

    // R4: drain all active frames, then one tick with none active
    for (int i = 0; i < NF + 2; i++) doOp(0, 0, 0, 1, "R4");
    doEvict(0);

    // Sweep of mixed operations
    for (int n = 0; n < 800; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: doOp(1, int'(lfsr[6:3]), 0, 0, "R2");
        3'd2:       doOp(1, int'(lfsr[6:3]), 1, 0, "R3");
        3'd3, 3'd4: doOp(0, 0, 0, 1, "R4");
        3'd5:       doOp(1, int'(lfsr[6:3]), lfsr[7], 1, "R5");
        default: begin
          if (lfsr[9:8] == 2'd0) doEvict(lfsr[10]);
          else doOp(0, 0, 0, 1, "R4");
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule